// File: doc/BRIEF.md
# Smart Card Cold-Reset Sequencer

This block runs the cold-reset phase of a contact smart card slot. It is clocked by the card clock. Software writes a control word with three bits: a reset request, a clock stop and an I/O disable. Software also writes a 16-bit release compare value. The sequence starts once the supply logic reports that the card voltage is good and the reset request is set. While the card reset line is held low, the block counts card clock cycles. It raises the card reset line when the count matches the compare value.

The same counter is then cleared and reused to measure when the card answers. The block watches the card I/O line through a synchronizer, looking for the first high-to-low transition, which is the start bit of the Answer To Reset. Transitions are ignored for a fixed blanking window after the sequence starts. If a start bit arrives while reset is still held low, the activation is flagged as failed. If it arrives after release, the answer is flagged as seen and the counter freezes at its arrival time.

Either flag pulls an active-low interrupt, and a status read clears both flags. The clock-stop and I/O-disable bits gate the card clock and I/O contact enables.

Top module: `sc_cold_reset`

## Requirements
- R1: After reset, the outputs are as follows: card_rst=0, card_clk_en=0, card_io_en=0, irq_n=1, both status flags 0 and stat_count=0.
- R2: A control write (ctl_we=1) stores bit 0 as the reset request, bit 1 as clock stop and bit 2 as I/O disable. The outputs follow as card_clk_en = NOT clock stop and card_io_en = NOT I/O disable. Both take effect one clock after the write.
- R3: The sequence leaves idle only while the reset request is set and vcc_ok=1. The first clock edge that sees both is cycle 0. Until then card_rst stays 0 and stat_count stays 0.
- R4: During the hold phase, stat_count equals the number of cycles since cycle 0. On the edge after stat_count equals the compare value C, card_rst rises and stat_count returns to 0. That edge is cycle C+1, and stat_count equals j-C-1 at cycle j after it.
- R5: A start bit is accepted only when it is seen at cycle 200 or later (BLANK_CYC=200). Earlier high-to-low transitions of card_io_in are ignored and set no flag.
- R6: card_io_in passes through a two-flop synchronizer. A line that goes low just after cycle d becomes a start-bit candidate at cycle d+2 and is acted on at cycle d+3.
- R7: If a start bit is accepted while card_rst is still high after release, stat_atr_ok is set and stat_count freezes at d+1-C.
- R8: If a start bit is accepted before release (d+2 <= C), stat_atr_early is set, card_rst stays 0 and stat_count freezes at d+2.
- R9: stat_count saturates at 0xFFFF and does not wrap.
- R10: irq_n is 0 whenever either status flag is set. A status_rd pulse clears both flags one clock later unless a new event arrives in the same cycle.
- R11: Clearing the reset request returns the block to idle on the next edge, with card_rst=0 and stat_count=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | {io_disable, clock_stop, reset_request} |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Release compare value |
| vcc_ok | input | 1 | Card supply ready |
| card_io_in | input | 1 | Card I/O line (asynchronous) |
| status_rd | input | 1 | Status read pulse, clears flags |
| card_rst | output | 1 | Card reset line, high when released |
| card_clk_en | output | 1 | Card clock enable |
| card_io_en | output | 1 | Card I/O contact enable |
| irq_n | output | 1 | Active-low interrupt |
| stat_atr_ok | output | 1 | Answer start bit seen after release |
| stat_atr_early | output | 1 | Answer arrived before release |
| stat_count | output | 16 | Cycle counter / arrival timestamp |

## Verification
The assertions assume four things about the inputs. The compare value is not rewritten while a sequence is running. vcc_ok does not drop during a sequence. status_rd is a single-cycle pulse. card_io_in returns high before a new sequence starts. The bench writes the compare value only while the block is idle, keeps vcc_ok high once a sequence has begun, and pulses status_rd for one cycle. It also raises the I/O line and clears the request between cases. The sweep places the falling edge of the I/O line at each cycle around the blanking boundary and around the release point, for several compare values.

// File: rtl/sc_rst_pkg.sv
package sc_rst_pkg;
  localparam int CNT_W = 16;
  localparam int CTL_REQ = 0;
  localparam int CTL_STOP = 1;
  localparam int CTL_IODIS = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LIVE = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    if (v == {CNT_W{1'b1}}) return v;
    return v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_max();
    return {CNT_W{1'b1}};
  endfunction
endpackage

// File: rtl/sc_start_bit_detect.sv
module sc_start_bit_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = prev_q & ~s2_q;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R6
endmodule

// File: rtl/sc_cycle_counter.sv
module sc_cycle_counter
  import sc_rst_pkg::*;
#(
  parameter int BLANK_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             cnt_inc,
  input  logic             blank_clr,
  input  logic             blank_run,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             cmp_hit,
  output logic             blank_done
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= sat_inc(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               blank_q <= '0;
    else if (blank_clr)                       blank_q <= '0;
    else if (blank_run && blank_q < BLANK_END) blank_q <= blank_q + 1'b1;
  end

  assign count      = cnt_q;
  assign cmp_hit    = (cnt_q == cmp_val);
  assign blank_done = (blank_q >= BLANK_END);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !cnt_clr && cnt_q == cnt_max()) |=> cnt_q == cnt_max()); // R9
  AST_BLANK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_done && !blank_clr) |=> blank_done); // R5
endmodule

// File: rtl/sc_flag_status.sv
module sc_flag_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ok,
  input  logic set_early,
  input  logic rd,
  output logic atr_ok,
  output logic atr_early,
  output logic irq_n
);
  logic ok_q, early_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      early_q <= 1'b0;
    end else begin
      ok_q    <= set_ok    | (ok_q    & ~rd);
      early_q <= set_early | (early_q & ~rd);
    end
  end

  assign atr_ok    = ok_q;
  assign atr_early = early_q;
  assign irq_n     = ~(ok_q | early_q);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !set_ok && !set_early) |=> irq_n); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_ok && set_early)); // R8
endmodule

// File: rtl/sc_cold_reset.sv
module sc_cold_reset
  import sc_rst_pkg::*;
#(
  parameter int          BLANK_CYC = 200,
  parameter logic [15:0] CMP_INIT  = 16'd400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [2:0]  ctl_wdata,
  input  logic        cmp_we,
  input  logic [15:0] cmp_wdata,
  input  logic        vcc_ok,
  input  logic        card_io_in,
  input  logic        status_rd,
  output logic        card_rst,
  output logic        card_clk_en,
  output logic        card_io_en,
  output logic        irq_n,
  output logic        stat_atr_ok,
  output logic        stat_atr_early,
  output logic [15:0] stat_count
);
  phase_e           phase_q, phase_d;
  logic             req_q, stop_q, iodis_q;
  logic [CNT_W-1:0] cmp_q;
  logic             rst_q;

  logic             io_fall, fall_ok;
  logic             cmp_hit, blank_done;
  logic [CNT_W-1:0] count;
  logic             start_ev, release_ev, ok_ev, early_ev, abort_ev;
  logic             cnt_clr, cnt_inc, blank_clr, blank_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      stop_q  <= 1'b1;
      iodis_q <= 1'b1;
    end else if (ctl_we) begin
      req_q   <= ctl_wdata[CTL_REQ];
      stop_q  <= ctl_wdata[CTL_STOP];
      iodis_q <= ctl_wdata[CTL_IODIS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= CMP_INIT;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  sc_start_bit_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (card_io_in),
    .fall    (io_fall)
  );

  assign fall_ok    = io_fall & blank_done & ((phase_q == PH_HOLD) | (phase_q == PH_LIVE));
  assign abort_ev   = ~req_q & (phase_q != PH_IDLE);
  assign start_ev   = (phase_q == PH_IDLE) & req_q & vcc_ok;
  assign early_ev   = req_q & fall_ok & (phase_q == PH_HOLD);
  assign ok_ev      = req_q & fall_ok & (phase_q == PH_LIVE);
  assign release_ev = req_q & (phase_q == PH_HOLD) & ~fall_ok & cmp_hit;

  always_comb begin
    phase_d = phase_q;
    if (abort_ev)             phase_d = PH_IDLE;
    else if (start_ev)        phase_d = PH_HOLD;
    else if (early_ev|ok_ev)  phase_d = PH_DONE;
    else if (release_ev)      phase_d = PH_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rst_q <= 1'b0;
    else if (abort_ev)   rst_q <= 1'b0;
    else if (release_ev) rst_q <= 1'b1;
  end

  assign cnt_clr   = (phase_q == PH_IDLE) | abort_ev | release_ev;
  assign cnt_inc   = req_q & ~fall_ok & ((phase_q == PH_HOLD) | (phase_q == PH_LIVE));
  assign blank_clr = (phase_q == PH_IDLE) | abort_ev;
  assign blank_run = (phase_q == PH_HOLD) | (phase_q == PH_LIVE);

  sc_cycle_counter #(.BLANK_CYC(BLANK_CYC)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .blank_clr  (blank_clr),
    .blank_run  (blank_run),
    .cmp_val    (cmp_q),
    .count      (count),
    .cmp_hit    (cmp_hit),
    .blank_done (blank_done)
  );

  sc_flag_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ok    (ok_ev),
    .set_early (early_ev),
    .rd        (status_rd),
    .atr_ok    (stat_atr_ok),
    .atr_early (stat_atr_early),
    .irq_n     (irq_n)
  );

  assign card_rst    = rst_q;
  assign card_clk_en = ~stop_q;
  assign card_io_en  = ~iodis_q;
  assign stat_count  = count;

  AST_WAIT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !vcc_ok) |=> phase_q == PH_IDLE); // R3
  AST_RELEASE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> ($past(cmp_hit) && stat_count == 16'd0)); // R4
  AST_BLANK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && $past(phase_q) != PH_DONE) |-> $past(blank_done)); // R5
  AST_EARLY_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    early_ev |=> (!card_rst && stat_atr_early)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !start_ev) |=> (!card_rst && stat_count == 16'd0)); // R11
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && req_q) |=> $stable(stat_count)); // R7
endmodule

// File: tb/sc_cold_reset_bench.sv
module sc_cold_reset_bench;
  localparam int PERIOD = 10;
  localparam int BLANK  = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = 3'b110;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        vcc_ok = 1'b0;
  logic        card_io_in = 1'b1;
  logic        status_rd = 1'b0;
  logic        card_rst, card_clk_en, card_io_en, irq_n;
  logic        stat_atr_ok, stat_atr_early;
  logic [15:0] stat_count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sc_cold_reset #(.BLANK_CYC(BLANK)) u_sc_cold_reset (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .vcc_ok(vcc_ok),
    .card_io_in(card_io_in), .status_rd(status_rd), .card_rst(card_rst),
    .card_clk_en(card_clk_en), .card_io_en(card_io_en), .irq_n(irq_n),
    .stat_atr_ok(stat_atr_ok), .stat_atr_early(stat_atr_early),
    .stat_count(stat_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = v;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic go_idle();
    card_io_in = 1'b1;
    wr_ctl(3'b000);
    repeat (4) @(negedge clk);
    read_status();
  endtask

  // One activation: line low just after cycle d, compare value c.
  task automatic run_case(input int c, input int d, input bit chk_irq);
    int t;
    go_idle();
    wr_cmp(16'(c));
    wr_ctl(3'b001);
    @(posedge clk);                 // cycle 0
    repeat (d) @(posedge clk);      // cycle d
    @(negedge clk); card_io_in = 1'b0;
    t = ((d + 3) > (c + 2) ? (d + 3) : (c + 2)) + 1;
    repeat (t - d) @(posedge clk);
    @(negedge clk);
    if (d < BLANK - 2) begin
      chk("R5 ok flag", int'(stat_atr_ok), 0);
      chk("R5 early flag", int'(stat_atr_early), 0);
      chk("R4 released", int'(card_rst), 1);
    end else if (d + 2 <= c) begin
      chk("R8 early flag", int'(stat_atr_early), 1);
      chk("R8 ok flag", int'(stat_atr_ok), 0);
      chk("R8 rst low", int'(card_rst), 0);
      chk("R8 count", int'(stat_count), d + 2);
    end else begin
      chk("R7 ok flag", int'(stat_atr_ok), 1);
      chk("R7 early flag", int'(stat_atr_early), 0);
      chk("R4 rst high", int'(card_rst), 1);
      chk("R7 count", int'(stat_count), d + 1 - c);
    end
    if (chk_irq && d >= BLANK - 2) begin
      chk("R10 irq asserted", int'(irq_n), 0);
      read_status();
      chk("R10 irq cleared", int'(irq_n), 1);
      chk("R10 flags cleared", int'(stat_atr_ok | stat_atr_early), 0);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 card_rst", int'(card_rst), 0);
    chk("R1 clk_en", int'(card_clk_en), 0);
    chk("R1 io_en", int'(card_io_en), 0);
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 flags", int'(stat_atr_ok | stat_atr_early), 0);
    chk("R1 count", int'(stat_count), 0);

    // R2 all gating combinations
    for (int v = 0; v < 4; v++) begin
      wr_ctl({v[1], v[0], 1'b0});
      chk("R2 clk_en", int'(card_clk_en), int'(!v[0]));
      chk("R2 io_en", int'(card_io_en), int'(!v[1]));
    end

    // R3 no start without supply
    wr_cmp(16'd3);
    wr_ctl(3'b001);
    repeat (20) @(negedge clk);
    chk("R3 count idle", int'(stat_count), 0);
    chk("R3 rst idle", int'(card_rst), 0);
    vcc_ok = 1'b1;
    @(posedge clk);                 // cycle 0
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 hold count", int'(stat_count), 2);
    chk("R4 hold rst", int'(card_rst), 0);
    repeat (2) @(posedge clk);      // cycle 4 = C+1
    @(negedge clk);
    chk("R4 rise", int'(card_rst), 1);
    chk("R4 count cleared", int'(stat_count), 0);
    repeat (5) @(negedge clk);
    // R11 abort
    wr_ctl(3'b000);
    @(negedge clk);
    chk("R11 rst low", int'(card_rst), 0);
    chk("R11 count zero", int'(stat_count), 0);

    // R5..R8, R10 sweep around blanking and release
    for (int c = 196; c <= 203; c++)
      for (int d = 195; d <= 206; d++)
        run_case(c, d, (d % 3) == 0);
    for (int d = 194; d <= 201; d++)
      run_case(10, d, 1'b1);

    // R10 event wins over read in the same cycle
    go_idle();
    wr_cmp(16'd5);
    wr_ctl(3'b001);
    @(posedge clk);
    repeat (BLANK + 5) @(posedge clk);
    @(negedge clk); card_io_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R10 set wins", int'(stat_atr_ok), 1);

    // R9 saturation
    go_idle();
    wr_cmp(16'd5);
    wr_ctl(3'b001);
    @(posedge clk);
    repeat (65545) @(posedge clk);
    @(negedge clk);
    chk("R9 saturate", int'(stat_count), 65535);
    repeat (3) @(negedge clk);
    chk("R9 no wrap", int'(stat_count), 65535);
    chk("R9 no flag", int'(stat_atr_ok), 0);
    card_io_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 late answer", int'(stat_atr_ok), 1);
    chk("R9 frozen max", int'(stat_count), 65535);

    go_idle();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule